// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block couples two data ports, A and B, through a pair of independent storage banks, one for each direction of transfer. Data entering on the A side is captured in the A-to-B bank, and that bank drives the B side. Data entering on the B side is captured in the B-to-A bank, and that bank drives the A side. Each direction has three active-low controls of its own. A chip select qualifies both loading and driving. A load strobe makes the bank follow its input while it is low and freezes it when it goes high. A drive strobe enables the outgoing port.

The model is synchronous to a system clock. A bank that is open passes its input straight through to the opposite port in the same cycle, and it stores the input sampled at each rising clock edge for as long as it stays open. Each outgoing port is a data bus with a separate drive flag, which stands in for a three-state pin. When the flag is low the bus reads zero. A conflict flag is raised whenever both ports are driven at once.

Top module: `latched_bus_xcvr`

## Requirements
- R1: While the synchronised reset is active, both drive flags are low. Both banks clear to zero, so after release a closed bank presents all zeros.
- R2: With `ab_sel_n`=0 and `ab_load_n`=0, the A-to-B bank is open: in the same cycle `b_out` equals `a_in` whenever B is driven, and each rising clock edge stores `a_in`.
- R3: With `ab_sel_n`=0 and `ab_load_n`=1, the A-to-B bank holds the value it sampled at the last clock edge on which it was open, whatever `a_in` does.
- R4: With `ab_sel_n`=1, the A-to-B bank keeps its contents whatever `ab_load_n` is, and B is not driven.
- R5: `b_oe` is 1 exactly when reset is released, `ab_sel_n`=0 and `ab_drv_n`=0. `b_out` then carries the A-to-B bank output; otherwise `b_out` is zero.
- R6: The B-to-A direction obeys R2 to R5 with `ba_sel_n`, `ba_load_n`, `ba_drv_n`, with `b_in` as its input and `a_out`/`a_oe` as its outputs.
- R7: The controls of one direction change neither the stored value nor the port outputs of the other direction.
- R8: `bus_conflict` is 1 exactly when `a_oe` and `b_oe` are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ab_sel_n | input | 1 | A-to-B chip select, active low |
| ab_load_n | input | 1 | A-to-B load strobe, active low (low = open) |
| ab_drv_n | input | 1 | B-port drive strobe, active low |
| ba_sel_n | input | 1 | B-to-A chip select, active low |
| ba_load_n | input | 1 | B-to-A load strobe, active low (low = open) |
| ba_drv_n | input | 1 | A-port drive strobe, active low |
| a_in | input | WIDTH | Data arriving on the A side |
| a_out | output | WIDTH | Data driven onto the A side, zero when idle |
| a_oe | output | 1 | A-side drive flag |
| b_in | input | WIDTH | Data arriving on the B side |
| b_out | output | WIDTH | Data driven onto the B side, zero when idle |
| b_oe | output | 1 | B-side drive flag |
| bus_conflict | output | 1 | Both ports driven at once |

## Verification
The assertions watch every cycle. They check that an open bank stores the input it sees, that a deselected or just-closed bank keeps its contents, that an idle port reads zero with its flag low, that an open and driven bank passes its input straight through, and that nothing drives during reset. Only the bench scenarios show the values that involve history across many cycles: what a bank holds after it closes while its input keeps changing, that it reopens correctly, that the two directions stay isolated while both move, and that the zero contents after reset are visible.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;
  // Per-direction control group, all active low.
  typedef struct packed {
    logic sel_n;
    logic load_n;
    logic drv_n;
  } dir_ctrl_t;
endpackage

// File: rtl/xcvr_rst_sync.sv
`timescale 1ns/1ps
module xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/xcvr_latch_bank.sv
`timescale 1ns/1ps
module xcvr_latch_bank
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dir_ctrl_t        ctl,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] lat_o,
  output logic             open_o
);
  logic [WIDTH-1:0] store_q;
  logic [WIDTH-1:0] store_d;
  logic             load_en;
  logic             load_q;
  logic             close_evt;

  // The bank is open (transparent) when selected and strobed low.
  always_comb begin
    open_o  = !ctl.sel_n && !ctl.load_n;
    load_en = open_o;
    store_d = din;
    lat_o   = open_o ? din : store_q;
  end

  // Registered copy of the strobe to spot its low-to-high transition.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= 1'b1;
    else        load_q <= ctl.load_n;
  end

  assign close_evt = !ctl.sel_n && ctl.load_n && !load_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       store_q[i] <= 1'b0;
      else if (load_en) store_q[i] <= store_d[i];
    end
  end

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.sel_n && !ctl.load_n) |=> (store_q == $past(din)));

  p_frozen_after_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt |=> $stable(store_q));

  p_deselect_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.sel_n |=> $stable(store_q));
endmodule

// File: rtl/xcvr_port_drive.sv
`timescale 1ns/1ps
module xcvr_port_drive
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             live,
  input  dir_ctrl_t        ctl,
  input  logic [WIDTH-1:0] lat,
  output logic [WIDTH-1:0] dout,
  output logic             drv
);
  always_comb begin
    drv  = live && !ctl.sel_n && !ctl.drv_n;
    dout = drv ? lat : '0;
  end
endmodule

// File: rtl/latched_bus_xcvr.sv
`timescale 1ns/1ps
module latched_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ab_sel_n,
  input  logic             ab_load_n,
  input  logic             ab_drv_n,
  input  logic             ba_sel_n,
  input  logic             ba_load_n,
  input  logic             ba_drv_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
  ,output logic            bus_conflict
);
  localparam int NDIR = 2;
  localparam int AB   = 0;
  localparam int BA   = 1;

  logic                  rst_sync_n;
  dir_ctrl_t             ctl     [NDIR];
  logic [WIDTH-1:0]      din     [NDIR];
  logic [WIDTH-1:0]      lat     [NDIR];
  logic [WIDTH-1:0]      dout    [NDIR];
  logic [NDIR-1:0]       drv;
  logic [NDIR-1:0]       is_open;

  always_comb begin
    ctl[AB] = '{sel_n: ab_sel_n, load_n: ab_load_n, drv_n: ab_drv_n};
    ctl[BA] = '{sel_n: ba_sel_n, load_n: ba_load_n, drv_n: ba_drv_n};
    din[AB] = a_in;
    din[BA] = b_in;
  end

  xcvr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    xcvr_latch_bank #(.WIDTH(WIDTH)) u_bank (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .ctl   (ctl[d]),
      .din   (din[d]),
      .lat_o (lat[d]),
      .open_o(is_open[d])
    );
    xcvr_port_drive #(.WIDTH(WIDTH)) u_drv (
      .live(rst_sync_n),
      .ctl (ctl[d]),
      .lat (lat[d]),
      .dout(dout[d]),
      .drv (drv[d])
    );
  end

  // A-to-B bank feeds the B side, B-to-A bank feeds the A side.
  always_comb begin
    b_out        = dout[AB];
    b_oe         = drv[AB];
    a_out        = dout[BA];
    a_oe         = drv[BA];
    bus_conflict = &drv;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_sync_n |-> (!a_oe && !b_oe));

  p_pass_through_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ab_sel_n && !ab_load_n && !ab_drv_n) |-> (b_oe && b_out == a_in));

  p_b_idle_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ab_sel_n || ab_drv_n) |-> (!b_oe && b_out == '0));

  p_a_idle_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ba_sel_n || ba_drv_n) |-> (!a_oe && a_out == '0));

  p_conflict_src_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_conflict |-> (!ab_sel_n && !ab_drv_n && !ba_sel_n && !ba_drv_n));
endmodule

// File: tb/tb_latched_bus_xcvr.sv
`timescale 1ns/1ps
module tb_latched_bus_xcvr;
  localparam int W = 8;

  typedef struct {
    logic [W-1:0] a_out;
    logic         a_oe;
    logic [W-1:0] b_out;
    logic         b_oe;
    logic         conf;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic ab_sel_n, ab_load_n, ab_drv_n, ba_sel_n, ba_load_n, ba_drv_n;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic a_oe, b_oe, bus_conflict;

  int checks = 0;
  int errors = 0;
  exp_t sb[$];
  logic [W-1:0] ref_ab, ref_ba;
  bit done = 0;

  always #4 clk = ~clk;

  latched_bus_xcvr #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .ab_sel_n(ab_sel_n), .ab_load_n(ab_load_n), .ab_drv_n(ab_drv_n),
    .ba_sel_n(ba_sel_n), .ba_load_n(ba_load_n), .ba_drv_n(ba_drv_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .bus_conflict(bus_conflict)
  );

  task automatic check1(string tag, logic [W-1:0] act, logic [W-1:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected outputs.
  task automatic step(string tag, logic [2:0] ab, logic [2:0] ba,
                      logic [W-1:0] ai, logic [W-1:0] bi);
    exp_t e;
    logic ab_open, ba_open;
    @(negedge clk);
    {ab_sel_n, ab_load_n, ab_drv_n} = ab;
    {ba_sel_n, ba_load_n, ba_drv_n} = ba;
    a_in = ai;
    b_in = bi;
    ab_open = !ab[2] && !ab[1];
    ba_open = !ba[2] && !ba[1];
    e.b_oe  = !ab[2] && !ab[0];
    e.a_oe  = !ba[2] && !ba[0];
    e.b_out = e.b_oe ? (ab_open ? ai : ref_ab) : '0;
    e.a_out = e.a_oe ? (ba_open ? bi : ref_ba) : '0;
    e.conf  = e.a_oe && e.b_oe;
    e.tag   = tag;
    sb.push_back(e);
    if (ab_open) ref_ab = ai;
    if (ba_open) ref_ba = bi;
  endtask

  // Monitor: compares the design's outputs with the queued expectation.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        check1(e.tag, b_out, e.b_out, "b_out");
        check1(e.tag, {7'd0, b_oe}, {7'd0, e.b_oe}, "b_oe");
        check1(e.tag, a_out, e.a_out, "a_out");
        check1(e.tag, {7'd0, a_oe}, {7'd0, e.a_oe}, "a_oe");
        check1(e.tag, {7'd0, bus_conflict}, {7'd0, e.conf}, "bus_conflict");
      end
    end
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // control words {sel_n, load_n, drv_n}
  localparam logic [2:0] OFF   = 3'b111;
  localparam logic [2:0] OPEN  = 3'b000;  // open and driving
  localparam logic [2:0] HOLDD = 3'b010;  // closed, driving
  localparam logic [2:0] OPENQ = 3'b001;  // open, not driving
  localparam logic [2:0] HOLDQ = 3'b011;  // closed, not driving
  localparam logic [2:0] DSEL  = 3'b100;  // deselected, strobe low

  initial begin
    rst_n = 1'b0;
    {ab_sel_n, ab_load_n, ab_drv_n} = 3'b010;
    {ba_sel_n, ba_load_n, ba_drv_n} = 3'b010;
    a_in = 8'h5A; b_in = 8'hA5;
    ref_ab = '0; ref_ba = '0;
    repeat (3) @(negedge clk);
    #2;
    // R1: selected and drive-strobed during reset, yet nothing drives.
    check1("R1", {6'd0, a_oe, b_oe}, 8'd0, "drive flags in reset");
    check1("R1", b_out, 8'd0, "b_out in reset");
    @(negedge clk);
    rst_n = 1'b1;
    {ab_sel_n, ab_load_n, ab_drv_n} = OFF;
    {ba_sel_n, ba_load_n, ba_drv_n} = OFF;
    repeat (3) @(negedge clk);

    // R1: cleared contents visible through closed banks.
    step("R1", HOLDD, HOLDD, 8'hFF, 8'hFF);
    // R2: pass-through and capture.
    step("R2", OPEN, OFF, 8'h3C, 8'h00);
    step("R2", OPEN, OFF, 8'hC3, 8'h00);
    // R3: close; input changes must not leak.
    step("R3", HOLDD, OFF, 8'h11, 8'h00);
    step("R3", HOLDD, OFF, 8'h22, 8'h00);
    // R5: open but not driving, then drive again.
    step("R5", OPENQ, OFF, 8'h77, 8'h00);
    step("R5", HOLDD, OFF, 8'h99, 8'h00);
    step("R5", HOLDQ, OFF, 8'h99, 8'h00);
    // R4: deselected with strobe low holds and stops driving.
    step("R4", DSEL, OFF, 8'hE1, 8'h00);
    step("R4", 3'b111, OFF, 8'hE2, 8'h00);
    step("R4", HOLDD, OFF, 8'hE3, 8'h00);
    // R6: B-to-A direction.
    step("R6", OFF, OPEN, 8'h00, 8'h81);
    step("R6", OFF, OPEN, 8'h00, 8'h42);
    step("R6", OFF, HOLDD, 8'h00, 8'h18);
    step("R6", OFF, DSEL, 8'h00, 8'h24);
    step("R6", OFF, HOLDD, 8'h00, 8'h24);
    // R7: toggling one side leaves the other bank alone.
    step("R7", OPENQ, HOLDD, 8'hAB, 8'hCD);
    step("R7", OPEN, HOLDD, 8'hBC, 8'hDE);
    step("R7", HOLDD, OPENQ, 8'hCD, 8'hEF);
    step("R7", HOLDD, HOLDD, 8'h01, 8'h02);
    // R8: both driving raises conflict; one side only does not.
    step("R8", OPEN, OPEN, 8'h0F, 8'hF0);
    step("R8", HOLDD, HOLDD, 8'h00, 8'h00);
    step("R8", HOLDQ, HOLDD, 8'h00, 8'h00);
    step("R8", OFF, OFF, 8'h00, 8'h00);
    // R2/R3: reopen after hold, then close.
    step("R2", OPEN, OFF, 8'h6E, 8'h00);
    step("R3", HOLDD, OFF, 8'h00, 8'h00);

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule